// File: doc/BRIEF.md
# Automatic Frequency Control Loop Sequencer

This block steers the frequency correction word that a receiver hands to its fractional-N synthesizer. An external discriminator delivers one signed frequency-error sample per received bit, marked by a one-cycle bit strobe. The sequencer runs repeated cycles. In each cycle it takes two samples and averages them. It scales the average down by a programmable gear shift and adds it to the running correction. The sum is clamped to a symmetric pull-in window set by an unsigned limit. The block then waits a programmable number of bit periods for the synthesizer to settle before it measures again.

Packet events gate the loop. Preamble detection freezes the correction for the rest of the packet. In multi-packet operation an end-of-packet pulse zeroes the correction and re-arms the loop so it can acquire the next packet from scratch. Clearing the enable forces the correction to zero. The current correction is presented as an 8-bit two's-complement value. A one-cycle strobe marks every clock in which that value has just changed.

Top module: `afc_seq`

## Requirements
- R1: A synchronous active-high reset clears the correction to 0, the update strobe to 0, the freeze state and the cycle position.
- R2: A cycle samples `err_in` on its first two accepted strobes. The average is floor((s1+s2)/2). The new correction appears on `corr_out` one clock after the strobe that carries the second sample.
- R3: With cycle setting N (1..7), one cycle lasts 2+2N accepted strobes: 2 for measuring and 2N for settling. The next measurement starts on the strobe that follows the last settling strobe.
- R4: With cycle setting 0 the correction is never updated by the loop.
- R5: The averaged error is arithmetically shifted right by the gear value (0..7) before it is added, so the sign is kept and the result rounds toward negative infinity.
- R6: Each updated correction is clamped to ±min(limit,127), where limit is an unsigned 8-bit value.
- R7: A high `pre_det` in a cycle blocks any update in that cycle. It also freezes the correction until the freeze is released by R8 or R9.
- R8: When `multi_pkt` is high, a high `pkt_end` clears the correction to 0, releases the freeze and restarts the cycle. When `multi_pkt` is low, `pkt_end` has no effect.
- R9: While `afc_en` is low, the correction is 0 from the next clock on, and the freeze and the cycle position are cleared.
- R10: `upd_stb` is high for exactly the clocks in which `corr_out` differs from its value one clock earlier.
- R11: The cycle advances and samples are taken only in clocks where `bit_stb` is high. Without a strobe, `err_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-cycle pulse per received bit |
| err_in | input | 8 | Signed frequency-error sample, valid with bit_stb |
| afc_en | input | 1 | Loop enable; low forces the correction to zero |
| cyc_set | input | 3 | Settling length selector N (settle = 2N bits); 0 stops updates |
| gear | input | 3 | Feedback right-shift amount |
| limit | input | 8 | Unsigned pull-in limit |
| multi_pkt | input | 1 | Multi-packet operation, lets pkt_end reset the loop |
| pre_det | input | 1 | Preamble detected, freezes the loop |
| pkt_end | input | 1 | End-of-packet pulse |
| corr_out | output | 8 | Signed correction word / readable correction value |
| upd_stb | output | 1 | High in each clock after corr_out changed |

## Verification
The bound checker watches several properties on every clock. It checks that the correction reads zero after a disabled clock and after a multi-packet end pulse. It checks that the correction stays put in clocks without a strobe, while frozen, and when the cycle setting is zero. It checks that every changed value sits inside the limit window and that the update strobe matches each change exactly. The exact averaging arithmetic, floor rounding under the gear shift, the 2+2N cycle length and the freeze persisting across later strobes can only be shown by the bench's scenarios. There, a behavioural model predicts `corr_out` and `upd_stb` clock by clock.

// File: rtl/afc_pkg.sv
package afc_pkg;
    // Action taken on the correction register in one clock
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_CAPTURE = 2'd1,
        ACT_APPLY   = 2'd2,
        ACT_CLEAR   = 2'd3
    } afc_act_e;
endpackage

// File: rtl/afc_phase.sv
// Position inside one measure/settle cycle; advances on accepted strobes.
module afc_phase #(
    parameter int CYC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             stb,
    input  logic [CYC_W-1:0] cyc_set,
    output logic             take_first,
    output logic             take_second
);
    localparam int CNT_W = CYC_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last_pos;

    // last position of a cycle is 2N+1 (2 measure + 2N settle strobes)
    assign last_pos = {cyc_set, 1'b1};

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (stb) begin
            cnt_d = (cnt_q == last_pos) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign take_first  = run & stb & (cnt_q == '0);
    assign take_second = run & stb & (cnt_q == CNT_W'(1));
endmodule

// File: rtl/afc_step.sv
// Average of two samples, gear shift, accumulate and symmetric clamp.
module afc_step #(
    parameter int ERR_W  = 8,
    parameter int CORR_W = 8,
    parameter int LIM_W  = 8,
    parameter int GEAR_W = 3
) (
    input  logic signed [ERR_W-1:0]  first_smp,
    input  logic signed [ERR_W-1:0]  second_smp,
    input  logic        [GEAR_W-1:0] gear,
    input  logic        [LIM_W-1:0]  limit,
    input  logic signed [CORR_W-1:0] corr_now,
    output logic signed [CORR_W-1:0] corr_new
);
    localparam int SUM_W = ERR_W + 1;                       // pair sum
    localparam int ACC_W = CORR_W + 1;                      // one guard bit
    localparam int CMP_W = ((LIM_W > CORR_W) ? LIM_W : CORR_W) + 2;
    localparam logic signed [CMP_W-1:0] MAX_POS = CMP_W'((1 << (CORR_W - 1)) - 1);

    logic signed [SUM_W-1:0] pair_sum, pair_avg, fb;
    logic signed [ACC_W-1:0] acc;
    logic signed [CMP_W-1:0] acc_x, lim_raw, lim_eff, lim_neg, clamped;

    always_comb begin
        pair_sum = SUM_W'(first_smp) + SUM_W'(second_smp);
        pair_avg = pair_sum >>> 1;
        fb       = pair_avg >>> gear;
        // requires ERR_W <= CORR_W so fb fits the accumulator
        acc      = ACC_W'(corr_now) + ACC_W'(fb);
        acc_x    = CMP_W'(acc);
        lim_raw  = CMP_W'({1'b0, limit});
        lim_eff  = (lim_raw > MAX_POS) ? MAX_POS : lim_raw;
        lim_neg  = -lim_eff;
        if (acc_x > lim_eff)      clamped = lim_eff;
        else if (acc_x < lim_neg) clamped = lim_neg;
        else                      clamped = acc_x;
        corr_new = CORR_W'(clamped);
    end
endmodule

// File: rtl/afc_seq.sv
module afc_seq
    import afc_pkg::*;
#(
    parameter int ERR_W  = 8,
    parameter int CORR_W = 8,
    parameter int LIM_W  = 8,
    parameter int CYC_W  = 3,
    parameter int GEAR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic [ERR_W-1:0]  err_in,
    input  logic              afc_en,
    input  logic [CYC_W-1:0]  cyc_set,
    input  logic [GEAR_W-1:0] gear,
    input  logic [LIM_W-1:0]  limit,
    input  logic              multi_pkt,
    input  logic              pre_det,
    input  logic              pkt_end,
    output logic [CORR_W-1:0] corr_out,
    output logic              upd_stb
);
    typedef struct packed {
        logic                     frz;
        logic signed [CORR_W-1:0] corr;
        logic signed [ERR_W-1:0]  acc;
        logic                     upd;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic                     clr_pkt, run, take_first, take_second;
    logic signed [CORR_W-1:0] corr_new;
    afc_act_e                 act;

    assign clr_pkt = multi_pkt & pkt_end;
    assign run     = afc_en & ~st_q.frz & ~pre_det & ~clr_pkt & (cyc_set != '0);

    afc_phase #(.CYC_W(CYC_W)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .stb         (bit_stb),
        .cyc_set     (cyc_set),
        .take_first  (take_first),
        .take_second (take_second)
    );

    afc_step #(
        .ERR_W (ERR_W),
        .CORR_W(CORR_W),
        .LIM_W (LIM_W),
        .GEAR_W(GEAR_W)
    ) u_step (
        .first_smp (st_q.acc),
        .second_smp($signed(err_in)),
        .gear      (gear),
        .limit     (limit),
        .corr_now  (st_q.corr),
        .corr_new  (corr_new)
    );

    always_comb begin
        if (!afc_en || clr_pkt) act = ACT_CLEAR;
        else if (take_second)   act = ACT_APPLY;
        else if (take_first)    act = ACT_CAPTURE;
        else                    act = ACT_HOLD;
    end

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_CLEAR:   begin
                st_d.corr = '0;
                st_d.acc  = '0;
            end
            ACT_CAPTURE: st_d.acc  = $signed(err_in);
            ACT_APPLY:   st_d.corr = corr_new;
            default:     ;
        endcase
        if (!afc_en || clr_pkt) st_d.frz = 1'b0;
        else if (pre_det)       st_d.frz = 1'b1;
        st_d.upd = (st_d.corr != st_q.corr);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign corr_out = st_q.corr;
    assign upd_stb  = st_q.upd;
endmodule

// File: rtl/afc_seq_chk.sv
module afc_seq_chk #(
    parameter int CORR_W = 8,
    parameter int LIM_W  = 8,
    parameter int CYC_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_stb,
    input logic              afc_en,
    input logic [CYC_W-1:0]  cyc_set,
    input logic [LIM_W-1:0]  limit,
    input logic              multi_pkt,
    input logic              pre_det,
    input logic              pkt_end,
    input logic [CORR_W-1:0] corr_out,
    input logic              upd_stb
);
    int corr_i;
    always_comb corr_i = int'($signed(corr_out));

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (corr_out == '0) && !upd_stb); // R1

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !afc_en |=> (corr_out == '0)); // R9

    AST_PKT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (multi_pkt && pkt_end) |=> (corr_out == '0)); // R8

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (afc_en && !bit_stb && !(multi_pkt && pkt_end)) |=> $stable(corr_out)); // R11

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (afc_en && pre_det && !(multi_pkt && pkt_end)) |=> $stable(corr_out)); // R7

    AST_ZERO_CYCLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (afc_en && cyc_set == '0 && !(multi_pkt && pkt_end)) |=> $stable(corr_out)); // R4

    AST_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ($past(afc_en) && upd_stb) |->
            (corr_i <= int'($past(limit))) && (corr_i >= -int'($past(limit)))); // R6

    AST_UPD_MATCHES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (upd_stb == (corr_out != $past(corr_out)))); // R10
endmodule

bind afc_seq afc_seq_chk #(
    .CORR_W(CORR_W),
    .LIM_W (LIM_W),
    .CYC_W (CYC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_stb  (bit_stb),
    .afc_en   (afc_en),
    .cyc_set  (cyc_set),
    .limit    (limit),
    .multi_pkt(multi_pkt),
    .pre_det  (pre_det),
    .pkt_end  (pkt_end),
    .corr_out (corr_out),
    .upd_stb  (upd_stb)
);

// File: tb/afc_seq_tb_top.sv
module afc_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic [7:0] err_in = '0;
    logic       afc_en = 1'b0;
    logic [2:0] cyc_set = 3'd1;
    logic [2:0] gear = '0;
    logic [7:0] limit = 8'd100;
    logic       multi_pkt = 1'b0;
    logic       pre_det = 1'b0;
    logic       pkt_end = 1'b0;
    logic [7:0] corr_out;
    logic       upd_stb;

    always #2.5 clk = ~clk;   // 200 MHz

    afc_seq dut_i (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .err_in(err_in),
        .afc_en(afc_en), .cyc_set(cyc_set), .gear(gear), .limit(limit),
        .multi_pkt(multi_pkt), .pre_det(pre_det), .pkt_end(pkt_end),
        .corr_out(corr_out), .upd_stb(upd_stb)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";

    // Behavioural reference model
    int m_corr = 0, m_acc = 0, m_pos = 0, m_frz = 0, m_upd = 0;
    always @(posedge clk) begin
        int nc, s, lim, clr, act;
        if (rst) begin
            m_corr = 0; m_acc = 0; m_pos = 0; m_frz = 0; m_upd = 0;
        end else begin
            clr = int'(multi_pkt && pkt_end);
            act = int'(afc_en && m_frz == 0 && !pre_det && clr == 0 && cyc_set != 0);
            nc  = m_corr;
            if (!afc_en || clr != 0) begin
                nc = 0; m_acc = 0;
            end else if (act != 0 && bit_stb) begin
                if (m_pos == 0) m_acc = int'($signed(err_in));
                else if (m_pos == 1) begin
                    s   = (m_acc + int'($signed(err_in))) >>> 1;
                    s   = s >>> gear;
                    lim = (int'(limit) > 127) ? 127 : int'(limit);
                    nc  = m_corr + s;
                    if (nc > lim) nc = lim;
                    if (nc < -lim) nc = -lim;
                end
            end
            if (act == 0) m_pos = 0;
            else if (bit_stb) m_pos = (m_pos == 1 + 2 * int'(cyc_set)) ? 0 : m_pos + 1;
            if (!afc_en || clr != 0) m_frz = 0;
            else if (pre_det) m_frz = 1;
            m_upd  = int'(nc != m_corr);
            m_corr = nc;
        end
    end

    task automatic cmp();
        if (!rst) begin
            n_chk++;
            if (int'($signed(corr_out)) != m_corr || int'(upd_stb) != m_upd) begin
                n_fail++;
                $display("FAIL %s cycle compare: corr=%0d upd=%0d expected corr=%0d upd=%0d",
                         tag, $signed(corr_out), upd_stb, m_corr, m_upd);
            end
        end
    endtask

    task automatic step(input logic s, input int e);
        @(negedge clk);
        cmp();
        bit_stb = s;
        err_in  = e[7:0];
        pre_det = 1'b0;
        pkt_end = 1'b0;
    endtask

    task automatic strobes(input int n, input int e);
        for (int i = 0; i < n; i++) step(1'b1, e);
    endtask

    task automatic expect_corr(input int v, input string rq);
        step(1'b0, 0);
        n_chk++;
        if (int'($signed(corr_out)) != v) begin
            n_fail++;
            $display("FAIL %s corr_out=%0d expected %0d", rq, $signed(corr_out), v);
        end
    endtask

    task automatic restart();
        step(1'b0, 0);
        afc_en = 1'b0;
        step(1'b0, 0);
        afc_en = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired, actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (corr_out !== 8'd0 || upd_stb !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 corr=%0d upd=%0d expected 0 0", corr_out, upd_stb);
        end
        afc_en = 1'b1;

        tag = "R2";
        strobes(4, 10);   expect_corr(10, "R2");
        strobes(4, 10);   expect_corr(20, "R2");
        restart();
        strobes(1, 7);    strobes(1, -2);  expect_corr(2, "R2");

        tag = "R10";
        restart();
        strobes(1, 5);
        step(1'b1, 5);              // second sample
        step(1'b0, 0);              // edge applied the update
        n_chk++;
        if (upd_stb !== 1'b1) begin
            n_fail++; $display("FAIL R10 upd_stb=%0d expected 1", upd_stb);
        end
        step(1'b0, 0);
        n_chk++;
        if (upd_stb !== 1'b0) begin
            n_fail++; $display("FAIL R10 upd_stb=%0d expected 0", upd_stb);
        end

        tag = "R3";
        restart();
        cyc_set = 3'd2;
        strobes(2, 8);   expect_corr(8, "R3");
        strobes(4, 8);   expect_corr(8, "R3");
        strobes(2, 8);   expect_corr(16, "R3");

        tag = "R11";
        for (int i = 0; i < 10; i++) step(1'b0, 99 - 20 * i);
        expect_corr(16, "R11");
        cyc_set = 3'd1;

        tag = "R5";
        restart();
        gear = 3'd2;
        strobes(1, -5);  strobes(1, -5);  expect_corr(-2, "R5");
        restart();
        gear = 3'd1;
        strobes(1, 9);   strobes(1, 9);   expect_corr(4, "R5");
        gear = 3'd0;

        tag = "R6";
        restart();
        limit = 8'd20;
        strobes(4, 100); expect_corr(20, "R6");
        strobes(4, -100); expect_corr(-20, "R6");
        restart();
        limit = 8'd200;
        strobes(4, 100); strobes(4, 100); expect_corr(127, "R6");
        strobes(4, -128); strobes(4, -128);
        limit = 8'd100;

        tag = "R4";
        restart();
        cyc_set = 3'd0;
        strobes(8, 50);  expect_corr(0, "R4");
        cyc_set = 3'd1;

        tag = "R9";
        restart();
        strobes(4, 30);  expect_corr(30, "R9");
        step(1'b1, 30);  afc_en = 1'b0;
        strobes(4, 30);  expect_corr(0, "R9");
        afc_en = 1'b1;

        tag = "R7";
        restart();
        strobes(4, 10);  expect_corr(10, "R7");
        step(1'b1, 10);  pre_det = 1'b1;
        step(1'b1, 10);
        strobes(8, 10);  expect_corr(10, "R7");

        tag = "R8";
        step(1'b0, 0);   pkt_end = 1'b1;      // multi_pkt low: ignored
        strobes(4, 10);  expect_corr(10, "R8");
        multi_pkt = 1'b1;
        step(1'b0, 0);   pkt_end = 1'b1;
        expect_corr(0, "R8");
        strobes(4, 10);  expect_corr(10, "R8");
        multi_pkt = 1'b0;

        step(1'b0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule